// File: doc/BRIEF.md
# Multi-Bank Pipe FIFO Status Tracker

This block keeps the status of one host-side endpoint pipe whose FIFO occupies one, two or three equal banks in a shared packet memory. It does not hold the data. It watches the byte strobes from software and from the bus side, the bank-complete events, and the stall and error flags. From these it reports four things: which bank is current, how many bytes that bank holds, whether software may move another byte, and whether the last allocation was accepted.

The direction of the pipe sets the meaning of its counts. On an OUT pipe, software fills a bank and the bus drains it. On an IN pipe, the bus fills a bank and software drains it. A control state machine has three states:
- `ST_UNCFG`: no valid allocation yet. Byte and bank events are ignored.
- `ST_RUN`: configured and free to move data.
- `ST_HOLD`: configured, but a stall or a pipe error is present.

Its transitions are:
- *alloc-accept*: any state goes to `ST_RUN`, or to `ST_HOLD` if a halt flag is up.
- *alloc-reject*: any state goes to `ST_UNCFG`.
- *halt*: `ST_RUN` goes to `ST_HOLD`.
- *resume*: `ST_HOLD` goes to `ST_RUN`.

Top module: `pipe_fifo_status`

## Requirements
- R1: The current-bank output only ever takes the values 0, 1 or 2; the value 3 is never produced. Each bank-complete event in a configured state advances it by one, wrapping to 0 after the last configured bank.
- R2: For an OUT pipe (direction input 0), the allowed flag is high while the bank count is below the bank size.
- R3: For an IN pipe (direction input 1), the allowed flag is high while the bank count is nonzero.
- R4: In the cycle after the stall flag or the error flag is high, the allowed flag is low.
- R5: The configuration-OK flag changes only on an allocate strobe. It is set only if all of the following hold:
  - the bank code is not 3 (codes 0, 1 and 2 mean 1, 2 and 3 banks);
  - the bank count is at most PIPE_MAX_BANKS;
  - the size code is at most MAX_SIZE_CODE, where the bank size is 8 << code bytes;
  - banks × size is at most MEM_BYTES.
- R6: For an OUT pipe, a software strobe adds one to the count and a bus strobe removes one.
- R7: For an IN pipe, a bus strobe adds one to the count and a software strobe removes one.
- R8: When both strobes arrive in one cycle, the count is unchanged. The count saturates at 0 and at the bank size and never wraps.
- R9: The byte-count and current-bank outputs follow the internal state one clock later than the allowed flag.
- R10: A bank-complete event takes priority over byte strobes in the same cycle. It reloads the count to 0 for OUT and to the bank size for IN.
- R11: After reset:
  - the count, bank, configuration-OK and allowed outputs are all 0;
  - strobes and bank events have no effect until an accepted allocation.
- R12: An allocate strobe clears the count and the bank index. It latches direction, bank count and size only when the configuration is accepted. Changing the configuration inputs without an allocate has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir_in | input | 1 | Pipe direction: 0 OUT, 1 IN |
| cfg_bank_code | input | 2 | Bank count code (0..2 gives 1..3 banks, 3 invalid) |
| cfg_size_code | input | 3 | Bank size code, size = 8 << code bytes |
| alloc_i | input | 1 | Allocate strobe; evaluates and latches configuration |
| sw_byte_i | input | 1 | One byte written (OUT) or read (IN) by software |
| bus_byte_i | input | 1 | One byte sent (OUT) or received (IN) on the bus |
| bank_done_i | input | 1 | Current bank completed |
| stall_i | input | 1 | Stall-received flag |
| pipe_err_i | input | 1 | Pipe error flag |
| cur_bank_o | output | 2 | Current bank index |
| rw_allowed_o | output | 1 | Software may move another byte |
| cfg_ok_o | output | 1 | Last allocation accepted |
| byte_cnt_o | output | CNT_W | Byte count of the current bank |

## Verification
Two events can meet in one cycle:
- A software strobe and a bus strobe can land together, which must cancel.
- A bank-complete event can coincide with byte strobes, which it must override.

A long pseudo-random phase drives all strobes independently, so both collisions recur in both directions and at both saturation limits. It also raises allocate, stall and error at low rates. Every clock, all four outputs are compared with a behavioural model that applies the same priorities and the one-cycle output lag. Directed checks fix the exact values at the collisions.

// File: rtl/pipe_status_pkg.sv
package pipe_status_pkg;

    typedef enum logic [1:0] {
        ST_UNCFG = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2
    } pipe_state_e;

    localparam int BANK_W = 2;

    function automatic int banks_from_code(input logic [1:0] code);
        return int'(code) + 1;
    endfunction

    function automatic int bytes_from_code(input logic [2:0] code);
        return 8 << code;
    endfunction

endpackage

// File: rtl/pipe_cfg_check.sv
module pipe_cfg_check
    import pipe_status_pkg::*;
#(
    parameter int PIPE_MAX_BANKS = 3,
    parameter int MAX_SIZE_CODE  = 6,
    parameter int MEM_BYTES      = 1024,
    parameter int CNT_W          = 10
) (
    input  logic [1:0]       bank_code,
    input  logic [2:0]       size_code,
    output logic             cfg_valid,
    output logic [1:0]       nbanks,
    output logic [CNT_W-1:0] bank_bytes
);

    int          nb_int;
    logic [31:0] sz_int;
    int          total;

    always_comb begin
        nb_int     = banks_from_code(bank_code);
        sz_int     = 32'(bytes_from_code(size_code));
        total      = nb_int * int'(sz_int);
        cfg_valid  = (bank_code != 2'd3)
                  && (nb_int <= PIPE_MAX_BANKS)
                  && (int'(size_code) <= MAX_SIZE_CODE)
                  && (total <= MEM_BYTES);
        nbanks     = 2'(nb_int);
        bank_bytes = sz_int[CNT_W-1:0];
    end

endmodule

// File: rtl/pipe_byte_counter.sv
module pipe_byte_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             enable,
    input  logic             inc,
    input  logic             dec,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_nx,
    output logic [CNT_W-1:0] cnt_q
);

    always_comb begin
        cnt_nx = cnt_q;
        if (clear) begin
            cnt_nx = '0;
        end else if (load) begin
            cnt_nx = load_val;
        end else if (enable && inc && !dec) begin
            if (cnt_q < limit) cnt_nx = cnt_q + 1'b1;
        end else if (enable && dec && !inc) begin
            if (cnt_q != '0) cnt_nx = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end

    // R8: the count never rises above the bank size
    assert_count_within_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    // R8: opposing strobes in one cycle cancel
    assert_inc_dec_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && inc && dec && !clear && !load) |=> $stable(cnt_q));

    // R8: no wrap below zero
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && dec && !inc && !clear && !load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/pipe_bank_seq.sv
module pipe_bank_seq
    import pipe_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [BANK_W-1:0] nbanks,
    output logic [BANK_W-1:0] bank_nx,
    output logic [BANK_W-1:0] bank_q
);

    logic [BANK_W-1:0] last_bank;

    always_comb begin
        last_bank = nbanks - 1'b1;
        bank_nx   = bank_q;
        if (clear)        bank_nx = '0;
        else if (advance) bank_nx = (bank_q >= last_bank) ? '0 : bank_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_nx;
    end

    // R1: reserved index never reached
    assert_bank_not_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q != BANK_W'(3));

    // R1: wrap after the last configured bank
    assert_bank_wraps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && bank_q == last_bank) |=> (bank_q == '0));

endmodule

// File: rtl/pipe_fifo_status.sv
module pipe_fifo_status
    import pipe_status_pkg::*;
#(
    parameter int PIPE_MAX_BANKS = 3,
    parameter int MAX_SIZE_CODE  = 6,
    parameter int MEM_BYTES      = 1024,
    localparam int CNT_W         = $clog2(8 << MAX_SIZE_CODE) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_dir_in,
    input  logic [1:0]       cfg_bank_code,
    input  logic [2:0]       cfg_size_code,
    input  logic             alloc_i,
    input  logic             sw_byte_i,
    input  logic             bus_byte_i,
    input  logic             bank_done_i,
    input  logic             stall_i,
    input  logic             pipe_err_i,
    output logic [1:0]       cur_bank_o,
    output logic             rw_allowed_o,
    output logic             cfg_ok_o,
    output logic [CNT_W-1:0] byte_cnt_o
);

    pipe_state_e       state_q, state_nx;
    logic              dir_q, dir_nx;
    logic [1:0]        nbanks_q, nbanks_nx;
    logic [CNT_W-1:0]  size_q, size_nx;
    logic              cfg_ok_q;

    logic              chk_valid;
    logic [1:0]        chk_nbanks;
    logic [CNT_W-1:0]  chk_bytes;

    logic              halt;
    logic              running;
    logic              cnt_inc, cnt_dec;
    logic [CNT_W-1:0]  reload_val;
    logic [CNT_W-1:0]  cnt_nx, cnt_q;
    logic [1:0]        bank_nx, bank_q;
    logic              allow_nx;

    logic              allowed_q;
    logic [CNT_W-1:0]  byte_cnt_q;
    logic [1:0]        cur_bank_q;

    pipe_cfg_check #(
        .PIPE_MAX_BANKS (PIPE_MAX_BANKS),
        .MAX_SIZE_CODE  (MAX_SIZE_CODE),
        .MEM_BYTES      (MEM_BYTES),
        .CNT_W          (CNT_W)
    ) u_cfg_check (
        .bank_code  (cfg_bank_code),
        .size_code  (cfg_size_code),
        .cfg_valid  (chk_valid),
        .nbanks     (chk_nbanks),
        .bank_bytes (chk_bytes)
    );

    // ---------------- control state machine: next state ----------------
    always_comb begin
        halt     = stall_i | pipe_err_i;
        state_nx = state_q;
        if (alloc_i) begin
            if (chk_valid) state_nx = halt ? ST_HOLD : ST_RUN;   // alloc-accept
            else           state_nx = ST_UNCFG;                  // alloc-reject
        end else begin
            unique case (state_q)
                ST_UNCFG: state_nx = ST_UNCFG;
                ST_RUN:   state_nx = halt ? ST_HOLD : ST_RUN;    // halt
                ST_HOLD:  state_nx = halt ? ST_HOLD : ST_RUN;    // resume
                default:  state_nx = ST_UNCFG;
            endcase
        end
    end

    // configuration latched on an accepted allocation only
    always_comb begin
        dir_nx    = dir_q;
        nbanks_nx = nbanks_q;
        size_nx   = size_q;
        if (alloc_i && chk_valid) begin
            dir_nx    = cfg_dir_in;
            nbanks_nx = chk_nbanks;
            size_nx   = chk_bytes;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_UNCFG;
            dir_q    <= 1'b0;
            nbanks_q <= 2'd1;
            size_q   <= CNT_W'(8);
            cfg_ok_q <= 1'b0;
        end else begin
            state_q  <= state_nx;
            dir_q    <= dir_nx;
            nbanks_q <= nbanks_nx;
            size_q   <= size_nx;
            if (alloc_i) cfg_ok_q <= chk_valid;
        end
    end

    // ---------------- datapath steering ----------------
    always_comb begin
        running    = (state_q != ST_UNCFG);
        cnt_inc    = dir_q ? bus_byte_i : sw_byte_i;
        cnt_dec    = dir_q ? sw_byte_i  : bus_byte_i;
        reload_val = dir_q ? size_q : '0;
    end

    pipe_byte_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (alloc_i),
        .load     (running && bank_done_i),
        .load_val (reload_val),
        .enable   (running),
        .inc      (cnt_inc),
        .dec      (cnt_dec),
        .limit    (size_q),
        .cnt_nx   (cnt_nx),
        .cnt_q    (cnt_q)
    );

    pipe_bank_seq u_bank_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (alloc_i),
        .advance (running && bank_done_i && !alloc_i),
        .nbanks  (nbanks_q),
        .bank_nx (bank_nx),
        .bank_q  (bank_q)
    );

    // allowed flag tracks the new state; count and bank outputs lag by a cycle
    always_comb begin
        allow_nx = (state_nx == ST_RUN)
                && (dir_nx ? (cnt_nx != '0) : (cnt_nx < size_nx));
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            allowed_q  <= 1'b0;
            byte_cnt_q <= '0;
            cur_bank_q <= '0;
        end else begin
            allowed_q  <= allow_nx;
            byte_cnt_q <= cnt_q;
            cur_bank_q <= bank_q;
        end
    end

    assign rw_allowed_o = allowed_q;
    assign byte_cnt_o   = byte_cnt_q;
    assign cur_bank_o   = cur_bank_q;
    assign cfg_ok_o     = cfg_ok_q;

    // R4: a halt flag blocks software access in the following cycle
    assert_halt_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i || pipe_err_i) |=> !rw_allowed_o);

    // R5: configuration status moves only with an allocate strobe
    assert_cfg_only_on_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_i |=> $stable(cfg_ok_o));

    // R10: an OUT bank completion empties the count
    assert_out_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && bank_done_i && !alloc_i && !dir_q) |=> (cnt_q == '0));

    // R11: no access while unconfigured
    assert_uncfg_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNCFG) |-> !rw_allowed_o);

endmodule

// File: tb/tb_pipe_fifo_status.sv
module tb_pipe_fifo_status;

    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_dir_in;
    logic [1:0]       cfg_bank_code;
    logic [2:0]       cfg_size_code;
    logic             alloc_i, sw_byte_i, bus_byte_i, bank_done_i, stall_i, pipe_err_i;
    logic [1:0]       cur_bank_o;
    logic             rw_allowed_o, cfg_ok_o;
    logic [CNT_W-1:0] byte_cnt_o;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    pipe_fifo_status dut (
        .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in),
        .cfg_bank_code(cfg_bank_code), .cfg_size_code(cfg_size_code),
        .alloc_i(alloc_i), .sw_byte_i(sw_byte_i), .bus_byte_i(bus_byte_i),
        .bank_done_i(bank_done_i), .stall_i(stall_i), .pipe_err_i(pipe_err_i),
        .cur_bank_o(cur_bank_o), .rw_allowed_o(rw_allowed_o),
        .cfg_ok_o(cfg_ok_o), .byte_cnt_o(byte_cnt_o)
    );

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_bank, m_ocnt, m_obank, m_nb, m_sz;
    bit m_ok, m_cfgd, m_allow, m_dir;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_bank = 0; m_ocnt = 0; m_obank = 0;
            m_ok = 0; m_cfgd = 0; m_allow = 0; m_dir = 0; m_nb = 1; m_sz = 8;
        end else begin
            int nb, sz;
            bit ok, up, dn;
            m_ocnt  = m_cnt;
            m_obank = m_bank;
            if (alloc_i) begin
                nb = int'(cfg_bank_code) + 1;
                sz = 8 << cfg_size_code;
                ok = (cfg_bank_code != 3) && (nb <= 3) && (cfg_size_code <= 6) && (nb * sz <= 1024);
                m_ok = ok; m_cfgd = ok;
                if (ok) begin m_dir = cfg_dir_in; m_nb = nb; m_sz = sz; end
                m_cnt = 0; m_bank = 0;
            end else if (m_cfgd) begin
                if (bank_done_i) begin
                    m_bank = (m_bank + 1) % m_nb;
                    m_cnt  = m_dir ? m_sz : 0;
                end else begin
                    up = m_dir ? bus_byte_i : sw_byte_i;
                    dn = m_dir ? sw_byte_i  : bus_byte_i;
                    if (up && !dn && m_cnt < m_sz) m_cnt++;
                    if (dn && !up && m_cnt > 0)    m_cnt--;
                end
            end
            m_allow = m_cfgd && !(stall_i || pipe_err_i) && (m_dir ? (m_cnt != 0) : (m_cnt < m_sz));
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    bit compare_on = 0;
    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            chk("R1/R10 cur_bank", int'(cur_bank_o), m_obank);
            chk("R2/R3/R4 rw_allowed", int'(rw_allowed_o), int'(m_allow));
            chk("R5 cfg_ok", int'(cfg_ok_o), int'(m_ok));
            chk("R6/R7/R8/R9 byte_cnt", int'(byte_cnt_o), m_ocnt);
        end
    end

    task automatic cyc(input bit sw, input bit bus, input bit dn, input bit al,
                       input bit st, input bit er);
        sw_byte_i = sw; bus_byte_i = bus; bank_done_i = dn;
        alloc_i = al; stall_i = st; pipe_err_i = er;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_alloc(input bit dir, input logic [1:0] bc, input logic [2:0] sc);
        cfg_dir_in = dir; cfg_bank_code = bc; cfg_size_code = sc;
        cyc(0, 0, 0, 1, 0, 0);
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        rst_n = 0; cfg_dir_in = 0; cfg_bank_code = 0; cfg_size_code = 0;
        alloc_i = 0; sw_byte_i = 0; bus_byte_i = 0; bank_done_i = 0; stall_i = 0; pipe_err_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk("R11 reset byte_cnt", int'(byte_cnt_o), 0);
        chk("R11 reset cur_bank", int'(cur_bank_o), 0);
        chk("R11 reset cfg_ok", int'(cfg_ok_o), 0);
        chk("R11 reset rw_allowed", int'(rw_allowed_o), 0);
        compare_on = 1;

        // R11: events ignored before allocation
        cyc(1, 0, 0, 0, 0, 0); cyc(0, 1, 1, 0, 0, 0); idle(2);
        chk("R11 ignored byte_cnt", int'(byte_cnt_o), 0);
        chk("R11 ignored cur_bank", int'(cur_bank_o), 0);

        // R5: rejected configurations
        do_alloc(0, 2'd3, 3'd0); idle(1);
        chk("R5 bank code 3 rejected", int'(cfg_ok_o), 0);
        do_alloc(0, 2'd0, 3'd7); idle(1);
        chk("R5 size above pipe limit rejected", int'(cfg_ok_o), 0);
        do_alloc(0, 2'd2, 3'd6); idle(1);
        chk("R5 memory overflow rejected", int'(cfg_ok_o), 0);
        do_alloc(0, 2'd1, 3'd6); idle(1);
        chk("R5 exact memory fit accepted", int'(cfg_ok_o), 1);

        // OUT pipe, 3 banks of 8 bytes
        do_alloc(0, 2'd2, 3'd0);
        chk("R2 OUT allowed after alloc", int'(rw_allowed_o), 1);
        for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, 0, 0);
        idle(2);
        chk("R8 saturate at bank size", int'(byte_cnt_o), 8);
        chk("R2 OUT full blocks", int'(rw_allowed_o), 0);
        cyc(1, 1, 0, 0, 0, 0); idle(2);
        chk("R8 simultaneous strobes cancel", int'(byte_cnt_o), 8);
        cyc(0, 1, 0, 0, 0, 0); idle(2);
        chk("R6 bus byte decrements OUT", int'(byte_cnt_o), 7);
        chk("R2 OUT not full allows", int'(rw_allowed_o), 1);
        cyc(1, 0, 1, 0, 0, 0); idle(2);
        chk("R10 bank done wins, OUT reload", int'(byte_cnt_o), 0);
        chk("R1 advance to bank 1", int'(cur_bank_o), 1);
        cyc(0, 0, 1, 0, 0, 0); idle(1);
        chk("R1 bank 2", int'(cur_bank_o), 2);
        cyc(0, 0, 1, 0, 0, 0); idle(1);
        chk("R1 wrap to bank 0", int'(cur_bank_o), 0);

        // R4: stall and error
        cyc(0, 0, 0, 0, 1, 0);
        chk("R4 stall blocks", int'(rw_allowed_o), 0);
        idle(1);
        chk("R4 resume after stall", int'(rw_allowed_o), 1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R4 error blocks", int'(rw_allowed_o), 0);
        idle(1);

        // R12: config inputs change without alloc
        cfg_dir_in = 1; cfg_bank_code = 2'd3; cfg_size_code = 3'd7;
        cyc(1, 0, 0, 0, 0, 0); idle(2);
        chk("R12 config ignored without alloc", int'(byte_cnt_o), 1);
        chk("R12 cfg_ok held", int'(cfg_ok_o), 1);

        // IN pipe, 2 banks of 16 bytes
        do_alloc(1, 2'd1, 3'd1); idle(1);
        chk("R12 alloc clears count", int'(byte_cnt_o), 0);
        chk("R3 IN empty blocks", int'(rw_allowed_o), 0);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R9 allowed leads", int'(rw_allowed_o), 1);
        chk("R9 count lags", int'(byte_cnt_o), 0);
        idle(1);
        chk("R9 count one cycle later", int'(byte_cnt_o), 1);
        cyc(0, 1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0); idle(2);
        chk("R7 IN bus inc, sw dec", int'(byte_cnt_o), 1);
        cyc(1, 0, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0); idle(2);
        chk("R8 saturate at zero", int'(byte_cnt_o), 0);
        cyc(0, 0, 1, 0, 0, 0); idle(2);
        chk("R10 IN reload to bank size", int'(byte_cnt_o), 16);
        chk("R1 IN bank 1", int'(cur_bank_o), 1);
        cyc(0, 0, 1, 0, 0, 0); idle(1);
        chk("R1 IN wrap with 2 banks", int'(cur_bank_o), 0);

        // pseudo-random mix
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[15:11] == 5'd0) begin
                cfg_dir_in = lfsr[2]; cfg_bank_code = lfsr[4:3]; cfg_size_code = {1'b0, lfsr[6:5]};
            end
            cyc(lfsr[0], lfsr[1], lfsr[9:5] == 5'd0, lfsr[15:11] == 5'd0,
                lfsr[10:7] == 4'd0, lfsr[14:11] == 4'd15);
        end
        idle(3);
        finish_run();
    end

endmodule